// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz tick, presented as a one-cycle enable on the system clock, into a periodic event. A free-running 16-bit count advances on every tick. An event fires when, after the increment, every count bit below log2 of the selected period is zero. Because of this, events always land on whole multiples of the period on that count, and not one period after the rate was chosen.

A 4-bit rate code selects the period. Code zero turns the generator off. Codes 1 and 2 stand in for codes 8 and 9. Every other code gives a period of 2^(code-1) ticks. The periodic enable starts and stops the generator. A divider-hold input clears the count and keeps the block silent.

Each event produces two one-cycle pulses for the flag storage that sits outside this block. One sets the periodic flag and the other sets the interrupt request.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset both pulse outputs are low and the tick count is zero, so with code 3 enabled the first event follows the fourth tick.
- R2: With rate code 0, no tick produces an event.
- R3: For codes 3 to 15 the event period is 2^(code-1) ticks; code 3 gives 4 and code 15 gives 16384.
- R4: Code 1 gives a period of 128 ticks and code 2 gives 256 ticks.
- R5: An event fires on a tick whose incremented 16-bit count has all bits below log2(period) at zero, so the first event after a change lands on the next multiple of the period.
- R6: While the periodic enable is low, no event is produced, but the count keeps advancing on ticks.
- R7: Each event shows as a one-cycle high on `flag_set_o` in the clock cycle after the tick cycle, and no pulse appears without a tick.
- R8: While `div_hold` is high the count is forced to zero and no event is produced.
- R9: A change of rate code produces no event until the count reaches the next multiple of the new period.
- R10: `irq_req_o` pulses exactly when `flag_set_o` pulses with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| rate_code | input | 4 | Period select; 0 disables, 1 and 2 alias to 8 and 9 |
| pie_en | input | 1 | Periodic interrupt enable; also runs the generator |
| div_hold | input | 1 | Holds the divider in reset, clearing the count |
| flag_set_o | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_req_o | output | 1 | One-cycle pulse that sets the interrupt request |

## Verification
The assertions assume a tick never lasts two consecutive clock cycles. They also assume the rate code, enable and hold inputs are steady around each tick edge. With those assumptions every pulse can be traced to the tick of the previous cycle and to the control values sampled with it. The bench holds each tick for exactly one cycle and keeps idle cycles between control changes. It changes controls only at the falling edge, away from the tick.

// File: rtl/periodic_rate_pkg.sv
package periodic_rate_pkg;
   // Code width and the aliasing of low codes onto slower rates
   localparam int CODE_W_DEF    = 4;
   localparam int CNT_W_DEF     = 16;
   localparam int ALIAS_TOP_DEF = 2;   // codes 1..ALIAS_TOP are remapped
   localparam int ALIAS_ADD_DEF = 7;   // by adding this offset

   typedef struct packed {
      logic       live;   // code is non-zero
      logic [4:0] shift;  // log2 of the period
   } rate_sel_t;
endpackage

// File: rtl/periodic_rate_decode.sv
module periodic_rate_decode
   import periodic_rate_pkg::*;
#(
   parameter int CODE_W    = CODE_W_DEF,
   parameter int CNT_W     = CNT_W_DEF,
   parameter int ALIAS_TOP = ALIAS_TOP_DEF,
   parameter int ALIAS_ADD = ALIAS_ADD_DEF
) (
   input  logic [CODE_W-1:0] code,
   output logic              live,
   output logic [CNT_W-1:0]  low_mask
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;

   if (MAX_CODE - 1 >= CNT_W) begin : g_bad_width
      $error("count width too small for the largest period");
   end
   if (ALIAS_TOP + ALIAS_ADD > MAX_CODE) begin : g_bad_alias
      $error("aliased code exceeds code range");
   end

   rate_sel_t sel;
   logic [CODE_W:0] eff_code;

   always_comb begin
      if ({1'b0, code} <= (CODE_W+1)'(ALIAS_TOP) && code != '0)
         eff_code = {1'b0, code} + (CODE_W+1)'(ALIAS_ADD);
      else
         eff_code = {1'b0, code};
      sel.live  = (code != '0);
      sel.shift = 5'(eff_code - 1'b1);
   end

   assign live = sel.live;

   // one mask bit per count bit: set below the period boundary
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign low_mask[i] = sel.live && (5'(i) < sel.shift);
   end
endmodule

// File: rtl/periodic_tick_counter.sv
module periodic_tick_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   output logic [CNT_W-1:0] cnt_inc
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_inc;
   end
endmodule

// File: rtl/periodic_event_gen.sv
module periodic_event_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   input  logic             live,
   input  logic             enable,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic [CNT_W-1:0] low_mask,
   output logic             flag_set,
   output logic             irq_req
);
   logic hit;

   assign hit = tick && !hold && live && enable && ((cnt_inc & low_mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_set <= 1'b0;
         irq_req  <= 1'b0;
      end else begin
         flag_set <= hit;
         irq_req  <= hit && enable;
      end
   end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
   import periodic_rate_pkg::*;
#(
   parameter int CODE_W    = CODE_W_DEF,
   parameter int CNT_W     = CNT_W_DEF,
   parameter int ALIAS_TOP = ALIAS_TOP_DEF,
   parameter int ALIAS_ADD = ALIAS_ADD_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              pie_en,
   input  logic              div_hold,
   output logic              flag_set_o,
   output logic              irq_req_o
);
   logic             live;
   logic [CNT_W-1:0] low_mask;
   logic [CNT_W-1:0] cnt_inc;

   periodic_rate_decode #(
      .CODE_W(CODE_W), .CNT_W(CNT_W),
      .ALIAS_TOP(ALIAS_TOP), .ALIAS_ADD(ALIAS_ADD)
   ) u_dec (
      .code(rate_code), .live(live), .low_mask(low_mask)
   );

   periodic_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_32k), .hold(div_hold),
      .cnt_inc(cnt_inc)
   );

   periodic_event_gen #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .tick(tick_32k), .hold(div_hold),
      .live(live), .enable(pie_en), .cnt_inc(cnt_inc), .low_mask(low_mask),
      .flag_set(flag_set_o), .irq_req(irq_req_o)
   );
endmodule

// File: rtl/periodic_rate_chk.sv
module periodic_rate_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_32k,
   input logic [CODE_W-1:0] rate_code,
   input logic              pie_en,
   input logic              div_hold,
   input logic              flag_set_o,
   input logic              irq_req_o
);
   AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_o |-> $past(tick_32k)); // R7
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_o |=> !flag_set_o); // R7
   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> flag_set_o); // R10
   AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_o |-> $past(rate_code) != '0); // R2
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_o |-> $past(pie_en)); // R6
   AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_o |-> !$past(div_hold)); // R8
endmodule

bind periodic_rate_gen periodic_rate_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
   .pie_en(pie_en), .div_hold(div_hold),
   .flag_set_o(flag_set_o), .irq_req_o(irq_req_o)
);

// File: tb/periodic_rate_gen_test.sv
module periodic_rate_gen_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       pie_en = 1'b0;
   logic       div_hold = 1'b0;
   logic       flag_set_o, irq_req_o;

   int checks = 0;
   int errors = 0;
   int model_cnt = 0;
   bit done = 0;

   periodic_rate_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
      .pie_en(pie_en), .div_hold(div_hold),
      .flag_set_o(flag_set_o), .irq_req_o(irq_req_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int period_of(input int c);
      if (c == 1) return 128;
      if (c == 2) return 256;
      return 1 << (c - 1);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one tick, then compare both outputs against the model
   task automatic one_tick(input string req, output int fired);
      int exp_evt;
      tick_32k = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_32k = 1'b0;
      if (div_hold) begin
         model_cnt = 0;
         exp_evt = 0;
      end else begin
         model_cnt = (model_cnt + 1) % 65536;
         exp_evt = (rate_code != 0 && pie_en &&
                    (model_cnt % period_of(int'(rate_code))) == 0) ? 1 : 0;
      end
      check({req, " flag"}, int'(flag_set_o), exp_evt);
      check({req, " irq"}, int'(irq_req_o), exp_evt);
      fired = int'(flag_set_o);
      // R7: gone one cycle later, no pulse without a tick
      @(negedge clk);
      check({req, " R7 idle"}, int'(flag_set_o) + int'(irq_req_o), 0);
   endtask

   task automatic run_ticks(input string req, input int n, output int count);
      int f;
      count = 0;
      for (int i = 0; i < n; i++) begin
         one_tick(req, f);
         count += f;
      end
   endtask

   task automatic clear_count();
      int f;
      div_hold = 1'b1;
      one_tick("R8 hold", f);
      div_hold = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset flag", int'(flag_set_o), 0);
      check("R1 reset irq", int'(irq_req_o), 0);
   endtask

   task automatic t_first_event();
      int n;
      rate_code = 4'd3; pie_en = 1'b1;
      @(negedge clk);
      run_ticks("R1 first", 3, n);
      check("R1 no event before 4th tick", n, 0);
      run_ticks("R1 fourth", 1, n);
      check("R1 event on 4th tick", n, 1);
   endtask

   task automatic t_code_periods();
      int n;
      clear_count();
      rate_code = 4'd3;
      run_ticks("R3 code3", 64, n);
      check("R3 code3 count", n, 16);
      rate_code = 4'd5;
      run_ticks("R3 code5", 64, n);
      check("R3 code5 count", n, 4);
      clear_count();
      rate_code = 4'd15;
      run_ticks("R3 code15", 16384, n);
      check("R3 code15 count", n, 1);
   endtask

   task automatic t_alias();
      int n;
      clear_count();
      rate_code = 4'd1;
      run_ticks("R4 code1", 256, n);
      check("R4 code1 count", n, 2);
      rate_code = 4'd2;
      run_ticks("R4 code2", 512, n);
      check("R4 code2 count", n, 2);
   endtask

   task automatic t_code_zero();
      int n;
      rate_code = 4'd0;
      run_ticks("R2 code0", 64, n);
      check("R2 code0 silent", n, 0);
   endtask

   task automatic t_disable_align();
      int n;
      clear_count();
      rate_code = 4'd3; pie_en = 1'b0;
      run_ticks("R6 disabled", 5, n);
      check("R6 disabled silent", n, 0);
      pie_en = 1'b1;
      run_ticks("R5 align pre", 2, n);
      check("R5 no event at count 6,7", n, 0);
      run_ticks("R5 align hit", 1, n);
      check("R5 event at count 8", n, 1);
   endtask

   task automatic t_hold();
      int n;
      rate_code = 4'd3; pie_en = 1'b1;
      div_hold = 1'b1;
      run_ticks("R8 held", 10, n);
      check("R8 held silent", n, 0);
      div_hold = 1'b0;
      run_ticks("R8 release", 4, n);
      check("R8 restart from zero", n, 1);
   endtask

   task automatic t_code_change();
      int n;
      clear_count();
      rate_code = 4'd15;
      run_ticks("R9 slow", 6, n);
      check("R9 slow silent", n, 0);
      rate_code = 4'd3;
      run_ticks("R9 switch", 1, n);
      check("R9 no spurious event", n, 0);
      run_ticks("R9 boundary", 1, n);
      check("R9 event at next multiple", n, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_event();
      t_code_periods();
      t_alias();
      t_code_zero();
      t_disable_align();
      t_hold();
      t_code_change();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule